// File: doc/BRIEF.md
# Staged Filter Coefficient Loader

This block sits between a simple register-write port and a polyphase filter datapath. The host first writes a set of 32-bit coefficient words into staging registers. It then writes one trigger address. That trigger write copies the staged words into the next phase slot of a coefficient bank. The trigger's own data word is copied into the same slot as its last word. A full program fills all sixteen phase slots, so the host repeats the stage-then-trigger sequence sixteen times.

A phase pointer selects the slot that each trigger fills. The pointer advances after each trigger and wraps from the last slot back to zero. Once sixteen triggers have landed since the last pointer clear, a sticky bank-valid flag is raised. The filter datapath reads the bank through a combinational read port. It uses the bank only while the bank is valid and the host has not set the bypass bit. Otherwise samples pass through unfiltered.

A sticky sequence-error flag records a trigger that arrives before every staging register has been rewritten since the previous trigger. The number of staging words is a parameter. Five gives the horizontal variant and two gives the vertical variant. Luma and chroma each get their own instance, with its own trigger address.

Top module: `coef_stage_loader`

## Requirements
- R1: After reset, load_phase is 0 and bank_valid, seq_err, bypass and use_bank are all 0. Every bank word reads 0.
- R2: A write to an address in 0..NUM_STAGE-1 stores wr_data in the staging word with that index. It changes neither the bank nor any flag.
- R3: A write to address NUM_STAGE (the trigger) copies staging words 0..NUM_STAGE-1 into words 0..NUM_STAGE-1 of the slot at load_phase. It also stores the trigger wr_data as word NUM_STAGE of that slot. The result is visible on rd_data from the next cycle.
- R4: Each trigger advances load_phase by one, wrapping from PHASES-1 to 0. Nothing else moves it except the clear write.
- R5: bank_valid rises on the trigger that fills slot PHASES-1. It then stays set across later wraps until a clear write.
- R6: If any staging word was not written since the previous trigger (or since reset or clear), the trigger still commits the slot and also sets seq_err. seq_err stays set until a clear write.
- R7: A write to address NUM_STAGE+2 (the clear) returns load_phase to 0. It also clears bank_valid, seq_err and the record of written staging words, and it leaves the bank contents unchanged.
- R8: A write to address NUM_STAGE+1 loads bypass from wr_data bit 0. use_bank is 1 exactly when bank_valid is 1 and bypass is 0.
- R9: Writes with wr_en low, or to addresses above NUM_STAGE+2, have no effect on any output or on the bank.
- R10: rd_data returns 0 when rd_word is NUM_STAGE+1 or greater.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| rd_phase | input | log2(PHASES) | Bank slot to read |
| rd_word | input | log2(NUM_STAGE+2) | Word within the slot to read |
| rd_data | output | DATA_W | Bank word (combinational) |
| load_phase | output | log2(PHASES) | Slot the next trigger fills |
| bank_valid | output | 1 | Sticky: all slots loaded since last clear |
| seq_err | output | 1 | Sticky: a trigger came with incomplete staging |
| bypass | output | 1 | Host bypass control bit |
| use_bank | output | 1 | Datapath should filter from the bank |

## Verification
The hardest state to reach from the ports is a pointer that has wrapped after at least sixteen triggers with no clear in between. In that state bank_valid must stay set while new triggers overwrite old slots and the error flag may be raised. A directed pass loads all sixteen slots cleanly and then reads back the full bank. It then forces an incomplete trigger and a wrap. A long seeded random run follows, with clear writes kept rare, so that many runs of sixteen or more triggers build up on top of earlier partial loads. Every step is compared against a bench model of the staging words, the written-word record and the bank.

// File: rtl/coef_ld_pkg.sv
package coef_ld_pkg;

  typedef enum logic [2:0] {
    ACC_NONE  = 3'd0,
    ACC_STAGE = 3'd1,
    ACC_TRIG  = 3'd2,
    ACC_CTRL  = 3'd3,
    ACC_CLR   = 3'd4
  } acc_e;

  // Classify a write address for a loader with n_stage staging words.
  function automatic acc_e classify(input int unsigned addr, input int unsigned n_stage);
    if (addr < n_stage)            return ACC_STAGE;
    else if (addr == n_stage)      return ACC_TRIG;
    else if (addr == n_stage + 1)  return ACC_CTRL;
    else if (addr == n_stage + 2)  return ACC_CLR;
    else                           return ACC_NONE;
  endfunction

endpackage

// File: rtl/coef_stage_regs.sv
module coef_stage_regs #(
  parameter int NUM_STAGE = 5,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          stage_we,
  input  logic [ADDR_W-1:0]             stage_idx,
  input  logic [DATA_W-1:0]             stage_data,
  input  logic                          trig,
  input  logic                          clr,
  output logic [NUM_STAGE*DATA_W-1:0]   stage_vec,
  output logic                          all_written
);

  logic [NUM_STAGE-1:0] mask_q, mask_d;

  for (genvar i = 0; i < NUM_STAGE; i++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_q;
    assign hit = stage_we && (int'(stage_idx) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= stage_data;
    end

    always_comb begin
      if (trig || clr) mask_d[i] = 1'b0;
      else if (hit)    mask_d[i] = 1'b1;
      else             mask_d[i] = mask_q[i];
    end

    assign stage_vec[i*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign all_written = &mask_q;

  // R6: the written-word record restarts after every trigger
  p_mask_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !all_written);

endmodule

// File: rtl/coef_phase_ctrl.sv
module coef_phase_ctrl #(
  parameter int PHASES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trig,
  input  logic                        clr,
  input  logic                        all_written,
  output logic [$clog2(PHASES)-1:0]   ptr,
  output logic                        complete,
  output logic                        err
);

  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          cmp_q, cmp_d;
  logic          err_q, err_d;

  always_comb begin
    ptr_d = ptr_q;
    cmp_d = cmp_q;
    err_d = err_q;
    if (clr) begin
      ptr_d = '0;
      cmp_d = 1'b0;
      err_d = 1'b0;
    end else if (trig) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (ptr_q == LAST) cmp_d = 1'b1;
      if (!all_written)  err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cmp_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      cmp_q <= cmp_d;
      err_q <= err_d;
    end
  end

  assign ptr      = ptr_q;
  assign complete = cmp_q;
  assign err      = err_q;

  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr && ptr == LAST) |=> (ptr == '0));
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !clr) |=> $stable(ptr));
  p_cmp_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !clr) |=> complete);
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr) |=> err);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr == '0 && !complete && !err));

endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int PHASES = 16,
  parameter int WORDS  = 6,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(PHASES)-1:0]     wr_phase,
  input  logic [WORDS*DATA_W-1:0]       wr_vec,
  input  logic [$clog2(PHASES)-1:0]     rd_phase,
  input  logic [$clog2(WORDS+1)-1:0]    rd_word,
  output logic [DATA_W-1:0]             rd_data
);

  localparam int RW = $clog2(WORDS + 1);

  logic [DATA_W-1:0] mem_q [PHASES][WORDS];

  for (genvar p = 0; p < PHASES; p++) begin : g_slot
    logic slot_we;
    assign slot_we = we && (int'(wr_phase) == p);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[p][w] <= '0;
        else if (slot_we) mem_q[p][w] <= wr_vec[w*DATA_W +: DATA_W];
      end
    end
  end

  logic          in_range;
  logic [RW-1:0] word_sel;

  always_comb begin
    in_range = (int'(rd_word) < WORDS);
    word_sel = in_range ? rd_word : '0;
    rd_data  = '0;
    if (in_range && int'(rd_phase) < PHASES)
      rd_data = mem_q[rd_phase][word_sel];
  end

  // R3: the trigger data lands in the final word of the addressed slot
  p_commit_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(wr_phase)][WORDS-1] == $past(wr_vec[(WORDS-1)*DATA_W +: DATA_W])));

endmodule

// File: rtl/coef_stage_loader.sv
module coef_stage_loader #(
  parameter int NUM_STAGE = 5,
  parameter int DATA_W    = 32,
  parameter int PHASES    = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic [$clog2(PHASES)-1:0]          rd_phase,
  input  logic [$clog2(NUM_STAGE+2)-1:0]     rd_word,
  output logic [DATA_W-1:0]                  rd_data,
  output logic [$clog2(PHASES)-1:0]          load_phase,
  output logic                               bank_valid,
  output logic                               seq_err,
  output logic                               bypass,
  output logic                               use_bank
);

  import coef_ld_pkg::*;

  localparam int WORDS = NUM_STAGE + 1;

  acc_e                         acc;
  logic                         is_stage, is_trig, is_ctrl, is_clr;
  logic [NUM_STAGE*DATA_W-1:0]  stage_vec;
  logic                         all_written;
  logic                         byp_q, byp_d;

  always_comb begin
    acc      = wr_en ? classify(int'(wr_addr), NUM_STAGE) : ACC_NONE;
    is_stage = (acc == ACC_STAGE);
    is_trig  = (acc == ACC_TRIG);
    is_ctrl  = (acc == ACC_CTRL);
    is_clr   = (acc == ACC_CLR);
  end

  coef_stage_regs #(.NUM_STAGE(NUM_STAGE), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_we   (is_stage),
    .stage_idx  (wr_addr),
    .stage_data (wr_data),
    .trig       (is_trig),
    .clr        (is_clr),
    .stage_vec  (stage_vec),
    .all_written(all_written)
  );

  coef_phase_ctrl #(.PHASES(PHASES)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (is_trig),
    .clr        (is_clr),
    .all_written(all_written),
    .ptr        (load_phase),
    .complete   (bank_valid),
    .err        (seq_err)
  );

  coef_bank #(.PHASES(PHASES), .WORDS(WORDS), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (is_trig),
    .wr_phase(load_phase),
    .wr_vec  ({wr_data, stage_vec}),
    .rd_phase(rd_phase),
    .rd_word (rd_word),
    .rd_data (rd_data)
  );

  always_comb begin
    byp_d = byp_q;
    if (is_ctrl) byp_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else        byp_q <= byp_d;
  end

  assign bypass   = byp_q;
  assign use_bank = bank_valid & ~byp_q;

  // R9: a cycle without any write leaves every flag where it was
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(load_phase) && $stable(bank_valid) && $stable(seq_err) && $stable(bypass)));

endmodule

// File: tb/coef_stage_loader_tb.sv
`timescale 1ns/1ps
module coef_stage_loader_tb;

  localparam int N  = 5;
  localparam int W  = N + 1;
  localparam int PH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_phase = '0;
  logic [2:0]  rd_word = '0;
  logic [31:0] rd_data;
  logic [3:0]  load_phase;
  logic        bank_valid, seq_err, bypass, use_bank;

  always #2 clk = ~clk;

  coef_stage_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_phase(rd_phase), .rd_word(rd_word), .rd_data(rd_data),
    .load_phase(load_phase), .bank_valid(bank_valid), .seq_err(seq_err),
    .bypass(bypass), .use_bank(use_bank)
  );

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_stage [N];
  logic [N-1:0] m_mask;
  logic [31:0] m_bank [PH][W];
  logic [3:0]  m_ptr;
  logic        m_cmp, m_err, m_byp;

  function automatic logic [31:0] exp_read(input int ph, input int w);
    return (w < W) ? m_bank[ph][w] : 32'h0;
  endfunction

  function automatic logic exp_use();
    return m_cmp && !m_byp;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_stage[i] = '0;
    for (int p = 0; p < PH; p++) for (int w = 0; w < W; w++) m_bank[p][w] = '0;
    m_mask = '0; m_ptr = '0; m_cmp = 1'b0; m_err = 1'b0; m_byp = 1'b0;
  endtask

  task automatic model_write(input logic en, input int a, input logic [31:0] d);
    if (!en) return;
    if (a < N) begin
      m_stage[a] = d; m_mask[a] = 1'b1;
    end else if (a == N) begin
      for (int i = 0; i < N; i++) m_bank[m_ptr][i] = m_stage[i];
      m_bank[m_ptr][N] = d;
      if (m_mask != '1) m_err = 1'b1;
      if (m_ptr == 4'(PH - 1)) m_cmp = 1'b1;
      m_ptr = m_ptr + 1'b1;
      m_mask = '0;
    end else if (a == N + 1) begin
      m_byp = d[0];
    end else if (a == N + 2) begin
      m_ptr = '0; m_cmp = 1'b0; m_err = 1'b0; m_mask = '0;
    end
  endtask

  task automatic do_write(input logic en, input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = en; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(en, a, d);
  endtask

  task automatic check_flags(input string req);
    chk(load_phase == m_ptr, {req, " load_phase"}, 32'(load_phase), 32'(m_ptr));
    chk(bank_valid == m_cmp, {req, " bank_valid"}, 32'(bank_valid), 32'(m_cmp));
    chk(seq_err == m_err,    {req, " seq_err"},    32'(seq_err),    32'(m_err));
    chk(bypass == m_byp,     {req, " bypass"},     32'(bypass),     32'(m_byp));
    chk(use_bank == exp_use(), {req, " use_bank"}, 32'(use_bank),   32'(exp_use()));
  endtask

  task automatic check_read(input int ph, input int w, input string req);
    rd_phase = 4'(ph); rd_word = 3'(w);
    #1;
    chk(rd_data == exp_read(ph, w), req, rd_data, exp_read(ph, w));
  endtask

  task automatic check_bank(input string req);
    for (int p = 0; p < PH; p++) for (int w = 0; w < 8; w++) check_read(p, w, req);
  endtask

  task automatic load_slot(input logic [31:0] base);
    for (int i = 0; i < N; i++) do_write(1'b1, i, base + 32'(i));
    do_write(1'b1, N, base ^ 32'hFFFF_0000);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_flags("R1");
    check_read(3, 2, "R1 bank zero");

    // R2 staging alone changes nothing visible
    for (int i = 0; i < N; i++) do_write(1'b1, i, 32'hA000_0000 + 32'(i));
    check_flags("R2");
    check_bank("R2 bank untouched");

    // R3 + R4 + R5 full clean load of all slots
    do_write(1'b1, N, 32'hBEEF_0000);
    check_read(0, N, "R3 trigger word");
    check_read(0, 1, "R3 staged word");
    check_flags("R4 advance");
    for (int s = 1; s < PH; s++) begin
      load_slot(32'h1000_0000 * 32'(s % 16) + 32'(s));
      if (s == PH - 2) check_flags("R5 not yet");
    end
    check_flags("R5 valid after 16");
    check_bank("R3 full bank");
    // R10 out-of-range word
    check_read(4, 6, "R10");
    check_read(9, 7, "R10");

    // R6 incomplete staging, also R4 wrap and R5 sticky
    do_write(1'b1, 0, 32'h0000_00C1);
    do_write(1'b1, N, 32'h0000_00C2);
    check_flags("R6 err after short stage");
    check_read(0, 0, "R6 slot still committed");
    check_read(0, N, "R6 slot still committed");

    // R8 bypass
    do_write(1'b1, N + 1, 32'h1);
    check_flags("R8 bypass on");
    do_write(1'b1, N + 1, 32'h2);
    check_flags("R8 bypass off");

    // R9 ignored writes
    do_write(1'b0, N, 32'hDEAD_DEAD);
    do_write(1'b1, 12, 32'hDEAD_DEAD);
    do_write(1'b1, 15, 32'hDEAD_DEAD);
    check_flags("R9");
    check_bank("R9 bank");

    // R7 clear
    do_write(1'b1, N + 2, 32'h0);
    check_flags("R7");
    check_bank("R7 bank kept");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      int a;
      logic en;
      r = int'($urandom % 100);
      en = 1'b1;
      if (r < 62)      a = int'($urandom % N);
      else if (r < 80) a = N;
      else if (r < 84) a = N + 1;
      else if (r < 85) a = N + 2;
      else if (r < 92) a = N + 3 + int'($urandom % (16 - N - 3));
      else begin a = int'($urandom % 16); en = 1'b0; end
      do_write(en, a, $urandom);
      check_flags("R4/R5/R6 random");
      check_read(int'($urandom % PH), int'($urandom % 8), "R3 random read");
    end
    check_bank("R3 final bank");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule